// File: doc/BRIEF.md
# Serial Output Control Register with Enable Interlocks

This block holds the 16-bit control word for an auxiliary serial audio output. A host writes it over a plain index-addressed bus (address, write strobe, write data) and reads it back combinationally. The block drives the master enable, the second-output enable, the clock-output enable and the two-bit format code to the serial transmitter, which lives outside this block.

The enable bits depend on one another and on an external power-down flag. The second-output enable and the clock-output enable both need the master enable. The clock-output enable is also blocked while power-down is high. Readback always shows the effective value, so a blocked bit reads 0.

Changes to the enables also reach a neighbouring GPIO configuration register, which the block owns and which the host can write at its own index. The master enable is tracked by a two-state machine:
- `SP_OFF` moves to `SP_ON` through the ENABLE transition, which is a control write with bit 15 = 1.
- `SP_ON` returns to `SP_OFF` through the DISABLE transition, which is a control write with bit 15 = 0.
- Every other cycle holds the state.

Top module: `serctl_reg`

## Requirements
- R1: After reset, the control register reads 0x0000, all enable and format outputs are 0, and every GPIO configuration bit is 1.
- R2: Control word layout: bit 15 is the master enable, bit 3 the second-output enable, bit 2 the clock-output enable and bits 1:0 the format. Reads of bits 14:4 return 0, and writes to those bits are ignored.
- R3: The second-output enable is stored as 1 only when the same write also carries bit 15 = 1.
- R4: A write that clears the master enable also clears the second-output enable and the clock-output enable in the same cycle.
- R5: The clock-output enable is stored as 1 only when the write carries bit 15 = 1 and power-down is 0.
- R6: While power-down is 1, the clock-output enable output and its read bit are 0 in that same cycle. The stored bit is cleared, so it stays 0 after power-down falls.
- R7: A 0-to-1 change of the master enable clears GPIO configuration bits 0 and 1. A 1-to-0 change sets them.
- R8: A 0-to-1 change of the second-output enable clears GPIO configuration bit 4. A 1-to-0 change, including the automatic clear of R4, sets it.
- R9: A write that leaves an enable at its current value does not alter the GPIO configuration bits that enable controls.
- R10: Writes to any index other than the control index (0x6A) leave the control register unchanged. A write to the GPIO index (0x4C) loads GPIO configuration bits 4:0 from write data bits 4:0.
- R11: The format field takes write data bits 1:0 on every control write, whatever the enables are, and drives the format output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 7 | Register index for both read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the index on `addr` (0 for other indices) |
| pwrdn | input | 1 | External power-down flag |
| ser_en | output | 1 | Master serial enable |
| ser_out2_en | output | 1 | Second data output enable |
| ser_clk_en | output | 1 | Effective clock-output enable |
| ser_fmt | output | 2 | Serial data format code |
| gpio_cfg | output | 5 | GPIO configuration register |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a clock-enable request and power-down. The bench raises power-down while the clock enable is set, then writes the clock enable again with power-down still high. The expected readback is 0 in both cases and after power-down falls.

The second pair is the master-enable side effect and the second-output side effect. A single write that drops the master enable while the second output is on must set GPIO bits 0, 1 and 4 together. A single write that raises both enables must clear all three together. Each result is compared against a GPIO value that the bench first loaded to a known pattern.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
    localparam int REG_W   = 16;
    localparam int B_MST   = 15;
    localparam int B_OUT2  = 3;
    localparam int B_SCLK  = 2;
    localparam int FMT_W   = 2;
    localparam int GP_LO_A = 0;
    localparam int GP_LO_B = 1;
    localparam int GP_OUT2 = 4;

    typedef enum logic {
        SP_OFF = 1'b0,
        SP_ON  = 1'b1
    } mode_e;
endpackage

// File: rtl/serctl_fsm.sv
module serctl_fsm
    import serctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic wr_master,
    output logic master_q,
    output logic master_rise,
    output logic master_fall
);
    mode_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SP_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        master_rise = 1'b0;
        master_fall = 1'b0;
        unique case (state_q)
            SP_OFF: if (ctrl_wr && wr_master) begin
                state_d     = SP_ON;
                master_rise = 1'b1;
            end
            SP_ON: if (ctrl_wr && !wr_master) begin
                state_d     = SP_OFF;
                master_fall = 1'b1;
            end
            default: state_d = SP_OFF;
        endcase
    end

    assign master_q = (state_q == SP_ON);
endmodule

// File: rtl/serctl_lanes.sv
module serctl_lanes
    import serctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             pwrdn,
    output logic             out2_q,
    output logic             sclk_eff,
    output logic [FMT_W-1:0] fmt_q,
    output logic             out2_rise,
    output logic             out2_fall
);
    logic out2_d, sclk_q, sclk_d;

    always_comb begin
        out2_d = out2_q;
        sclk_d = sclk_q & ~pwrdn;
        if (ctrl_wr) begin
            out2_d = wdata[B_OUT2] & wdata[B_MST];
            sclk_d = wdata[B_SCLK] & wdata[B_MST] & ~pwrdn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out2_q <= 1'b0;
            sclk_q <= 1'b0;
            fmt_q  <= '0;
        end else begin
            out2_q <= out2_d;
            sclk_q <= sclk_d;
            if (ctrl_wr) fmt_q <= wdata[FMT_W-1:0];
        end
    end

    assign out2_rise = ~out2_q & out2_d;
    assign out2_fall = out2_q & ~out2_d;
    assign sclk_eff  = sclk_q & ~pwrdn;
endmodule

// File: rtl/serctl_gpio.sv
module serctl_gpio
    import serctl_pkg::*;
#(
    parameter int GPIO_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gpio_wr,
    input  logic [GPIO_W-1:0] wbits,
    input  logic              master_rise,
    input  logic              master_fall,
    input  logic              out2_rise,
    input  logic              out2_fall,
    output logic [GPIO_W-1:0] cfg_q
);
    for (genvar i = 0; i < GPIO_W; i++) begin : g_bit
        logic set_i, clr_i;
        if (i == GP_LO_A || i == GP_LO_B) begin : g_mst
            assign set_i = master_fall;
            assign clr_i = master_rise;
        end else if (i == GP_OUT2) begin : g_out2
            assign set_i = out2_fall;
            assign clr_i = out2_rise;
        end else begin : g_free
            assign set_i = 1'b0;
            assign clr_i = 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cfg_q[i] <= 1'b1;
            else if (gpio_wr) cfg_q[i] <= wbits[i];
            else if (clr_i)   cfg_q[i] <= 1'b0;
            else if (set_i)   cfg_q[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/serctl_reg.sv
module serctl_reg
    import serctl_pkg::*;
#(
    parameter int              ADDR_W   = 7,
    parameter int              GPIO_W   = 5,
    parameter logic [ADDR_W-1:0] CTRL_IDX = 7'h6A,
    parameter logic [ADDR_W-1:0] GPIO_IDX = 7'h4C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              pwrdn,
    output logic              ser_en,
    output logic              ser_out2_en,
    output logic              ser_clk_en,
    output logic [FMT_W-1:0]  ser_fmt,
    output logic [GPIO_W-1:0] gpio_cfg
);
    localparam int PAD_W = REG_W - GPIO_W;

    logic ctrl_wr, gpio_wr;
    logic m_rise, m_fall, o_rise, o_fall;

    assign ctrl_wr = wr_en && (addr == CTRL_IDX);
    assign gpio_wr = wr_en && (addr == GPIO_IDX);

    serctl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .wr_master  (wdata[B_MST]),
        .master_q   (ser_en),
        .master_rise(m_rise),
        .master_fall(m_fall)
    );

    serctl_lanes u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .wdata    (wdata),
        .pwrdn    (pwrdn),
        .out2_q   (ser_out2_en),
        .sclk_eff (ser_clk_en),
        .fmt_q    (ser_fmt),
        .out2_rise(o_rise),
        .out2_fall(o_fall)
    );

    serctl_gpio #(.GPIO_W(GPIO_W)) u_gpio (
        .clk        (clk),
        .rst_n      (rst_n),
        .gpio_wr    (gpio_wr),
        .wbits      (wdata[GPIO_W-1:0]),
        .master_rise(m_rise),
        .master_fall(m_fall),
        .out2_rise  (o_rise),
        .out2_fall  (o_fall),
        .cfg_q      (gpio_cfg)
    );

    always_comb begin
        rdata = '0;
        if (addr == CTRL_IDX) begin
            rdata[B_MST]         = ser_en;
            rdata[B_OUT2]        = ser_out2_en;
            rdata[B_SCLK]        = ser_clk_en;
            rdata[FMT_W-1:0]     = ser_fmt;
        end else if (addr == GPIO_IDX) begin
            rdata = {{PAD_W{1'b0}}, gpio_cfg};
        end
    end
endmodule

// File: rtl/serctl_chk.sv
module serctl_chk #(
    parameter int              ADDR_W   = 7,
    parameter int              GPIO_W   = 5,
    parameter logic [ADDR_W-1:0] CTRL_IDX = 7'h6A
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [15:0]       rdata,
    input logic              pwrdn,
    input logic              ser_en,
    input logic              ser_out2_en,
    input logic              ser_clk_en,
    input logic [GPIO_W-1:0] gpio_cfg
);
    AST_OUT2_NEEDS_MST: assert property (@(posedge clk) disable iff (!rst_n) ser_out2_en |-> ser_en); // R3
    AST_CLK_NEEDS_MST: assert property (@(posedge clk) disable iff (!rst_n) ser_clk_en |-> ser_en); // R5
    AST_CLK_PWRDN_ZERO: assert property (@(posedge clk) disable iff (!rst_n) pwrdn |-> !ser_clk_en); // R6
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (addr == CTRL_IDX) |-> (rdata[14:4] == '0)); // R2
    AST_MST_RISE_GPIO: assert property (@(posedge clk) disable iff (!rst_n) $rose(ser_en) |-> (gpio_cfg[1:0] == 2'b00)); // R7
    AST_MST_FALL_GPIO: assert property (@(posedge clk) disable iff (!rst_n) $fell(ser_en) |-> (gpio_cfg[1:0] == 2'b11)); // R7
    AST_OUT2_RISE_GPIO: assert property (@(posedge clk) disable iff (!rst_n) $rose(ser_out2_en) |-> !gpio_cfg[4]); // R8
    AST_OUT2_FALL_GPIO: assert property (@(posedge clk) disable iff (!rst_n) $fell(ser_out2_en) |-> gpio_cfg[4]); // R8
    AST_MST_FALL_OUT2: assert property (@(posedge clk) disable iff (!rst_n) $fell(ser_en) |-> !ser_out2_en); // R4
    AST_NOWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(ser_en) && $stable(ser_out2_en)); // R10
endmodule

bind serctl_reg serctl_chk #(
    .ADDR_W  (ADDR_W),
    .GPIO_W  (GPIO_W),
    .CTRL_IDX(CTRL_IDX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .rdata      (rdata),
    .pwrdn      (pwrdn),
    .ser_en     (ser_en),
    .ser_out2_en(ser_out2_en),
    .ser_clk_en (ser_clk_en),
    .gpio_cfg   (gpio_cfg)
);

// File: tb/sim_serctl_reg.sv
`timescale 1ns/1ps
module sim_serctl_reg;
    localparam logic [6:0] CTRL = 7'h6A;
    localparam logic [6:0] GPIO = 7'h4C;

    typedef struct {
        string       tag;
        logic [15:0] ctrl;
        logic [4:0]  gpio;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  addr = CTRL;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        pwrdn = 1'b0;
    logic        ser_en, ser_out2_en, ser_clk_en;
    logic [1:0]  ser_fmt;
    logic [4:0]  gpio_cfg;

    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    serctl_reg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pwrdn(pwrdn), .ser_en(ser_en), .ser_out2_en(ser_out2_en),
        .ser_clk_en(ser_clk_en), .ser_fmt(ser_fmt), .gpio_cfg(gpio_cfg)
    );

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = CTRL;
    endtask

    task automatic expect_now(input string tag, input logic [15:0] c, input logic [4:0] g);
        exp_t e;
        e.tag = tag; e.ctrl = c; e.gpio = g;
        sb.push_back(e);
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                logic [15:0] outw;
                e = sb.pop_front();
                outw = {ser_en, 11'b0, ser_out2_en, ser_clk_en, ser_fmt};
                n_run++;
                if (rdata !== e.ctrl || outw !== e.ctrl || gpio_cfg !== e.gpio) begin
                    n_fail++;
                    $display("FAIL %s: rdata=%h outs=%h gpio=%h expected ctrl=%h gpio=%h",
                             e.tag, rdata, outw, gpio_cfg, e.ctrl, e.gpio);
                end
            end
        end
    end

    initial begin : watchdog
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_now("R1 reset", 16'h0000, 5'h1F);
        wr(CTRL, 16'h000C);
        expect_now("R3 R5 enables without master", 16'h0000, 5'h1F);
        wr(CTRL, 16'h7FF2);
        expect_now("R2 R11 reserved ignored, fmt", 16'h0002, 5'h1F);
        wr(CTRL, 16'h8001);
        expect_now("R7 master rise", 16'h8001, 5'h1C);
        wr(CTRL, 16'h800D);
        expect_now("R8 R5 out2 and clk on", 16'h800D, 5'h0C);
        wr(7'h10, 16'h0000);
        expect_now("R10 other index", 16'h800D, 5'h0C);
        wr(GPIO, 16'h001F);
        expect_now("R10 gpio index load", 16'h800D, 5'h1F);
        wr(CTRL, 16'h800D);
        expect_now("R9 same value rewrite", 16'h800D, 5'h1F);
        @(negedge clk); pwrdn = 1'b1;
        expect_now("R6 pwrdn masks clk", 16'h8009, 5'h1F);
        wr(CTRL, 16'h800F);
        expect_now("R5 clk write during pwrdn", 16'h800B, 5'h1F);
        @(negedge clk); pwrdn = 1'b0;
        expect_now("R6 clk stays clear", 16'h800B, 5'h1F);
        wr(GPIO, 16'h0000);
        expect_now("R10 gpio cleared by host", 16'h800B, 5'h00);
        wr(CTRL, 16'h0007);
        expect_now("R4 R7 R8 master drop", 16'h0003, 5'h13);
        wr(CTRL, 16'h800C);
        expect_now("R7 R8 both rise", 16'h800C, 5'h00);
        wr(CTRL, 16'h8004);
        expect_now("R8 out2 fall", 16'h8004, 5'h10);
        wr(CTRL, 16'h0000);
        expect_now("R4 R7 master off", 16'h0000, 5'h13);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule